// File: doc/BRIEF.md
# Escalating Four-Stage Watchdog

This block is a watchdog that software must service regularly. When the servicing stops, it escalates through four stages in a fixed order. Each stage waits for its own timeout, counted in ticks. When that timeout runs out, the stage performs its own action: nothing, a level interrupt, a CPU reset pulse or a system reset pulse. The sequencer then moves to the next stage and wraps from stage 3 back to stage 0. The tick comes from a programmable clock divider. The default divide of 80 makes one tick per microsecond from an 80 MHz clock.

All configuration sits behind a key lock. A configuration write lands only while the lock is open. Writing the 32-bit key word to the lock register opens it, and writing any other word to that register closes it again. Servicing (the feed write), the interrupt clear and the lock register itself are always accepted. A feed, an accepted configuration write, or the watchdog being stopped all return the sequencer to stage 0 with its counters cleared.

The write port is a plain single-cycle strobe with address and data. It has no back-pressure, because every write completes in the cycle it is presented. The reset outputs are active-high pulses whose lengths are programmable. Distributing those pulses is left to the surrounding chip.

Top module: `wdg_escalator`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it, `irq_o`, `cpu_rst_o` and `sys_rst_o` are low, the lock is closed, the stage is 0, and the control register holds all actions off, the watchdog stopped, both pulse lengths 7 and a divide of 80.
- R2: The register addresses are: 0 lock, 1 control, 2 divide, 3 feed, 4 to 7 the timeouts of stages 0 to 3, and 8 interrupt clear. Writes to addresses 1, 2 and 4 to 7 take effect only while the lock is open. A write of 32'h50D8_3AA1 to address 0 opens the lock, and any other value written there closes it. A write refused by the lock changes nothing and does not restart the sequence.
- R3: Address 2 bits [15:0] hold the divide D. While running, one tick is produced every D clocks, and a D of 0 behaves as 1.
- R4: A stage whose action is not off expires on the tick that brings its count of ticks to its timeout (a timeout of 0 behaves as 1). The stage index then advances and wraps from 3 to 0.
- R5: Control bits [2s+3:2s+2] hold the action of stage s: 0 off, 1 interrupt, 2 CPU reset, 3 system reset. An off stage is passed over in one clock without firing and without counting.
- R6: A feed write, an accepted configuration write, or the watchdog being stopped clears the tick divider and the tick count and selects stage 0. A feed in the same cycle as an expiry suppresses that expiry.
- R7: An interrupt action sets `irq_o` one clock after the expiry. It stays high until a write to address 8 with bit 0 set, which clears it on the next edge. If the set and the clear fall in the same cycle, the set wins.
- R8: Control bits [12:10] (CPU) and [15:13] (system) hold a length L. The matching reset output goes high one clock after the expiry and stays high for L+1 clocks. A new firing reloads the length.
- R9: Control bit 0 is the run enable and bit 1 is the flash-boot enable. The watchdog runs while either of them is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 32 | Write data |
| irq_o | output | 1 | Level interrupt, held until cleared |
| cpu_rst_o | output | 1 | CPU reset pulse |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
Two collisions get the most attention. The first is an interrupt-stage expiry landing in the same cycle as an interrupt-clear write. The second is a feed landing in the same cycle as an expiry. Each is provoked by sweeping the delay between a feed and the competing write over more cycles than one stage lasts, so that some step of the sweep must coincide with the expiry. The behavioural model judges each step cycle by cycle: the set must win over the clear, and the feed must win over the expiry. The bench also requires that both coincidences actually occurred during the sweep.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int NSTG   = 4;
  localparam int ADDR_W = 4;
  localparam int CTRL_W = 16;

  typedef enum logic [1:0] {
    ACT_OFF = 2'd0,
    ACT_IRQ = 2'd1,
    ACT_CPU = 2'd2,
    ACT_SYS = 2'd3
  } act_e;

  localparam logic [ADDR_W-1:0] A_LOCK = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd1;
  localparam logic [ADDR_W-1:0] A_DIV  = 4'd2;
  localparam logic [ADDR_W-1:0] A_FEED = 4'd3;
  localparam logic [ADDR_W-1:0] A_TMO0 = 4'd4;
  localparam logic [ADDR_W-1:0] A_ICLR = 4'd8;

  // control register field positions
  localparam int B_RUN   = 0;
  localparam int B_FBOOT = 1;
  localparam int B_ACT0  = 2;
  localparam int B_CLEN  = 10;
  localparam int B_SLEN  = 13;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TMO_W  = 32,
  parameter int PRE_W  = 16,
  parameter int PLEN_W = 3,
  parameter logic [DATA_W-1:0] KEY = 32'h50D8_3AA1,
  parameter int PRE_RST = 80,
  parameter logic [TMO_W-1:0] TMO_RST = '1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  output logic                        unlocked_o,
  output logic                        run_o,
  output logic                        restart_o,
  output logic                        irq_clr_o,
  output logic [NSTG-1:0][1:0]        act_o,
  output logic [NSTG-1:0][TMO_W-1:0]  tmo_o,
  output logic [PRE_W-1:0]            div_o,
  output logic [PLEN_W-1:0]           cpu_len_o,
  output logic [PLEN_W-1:0]           sys_len_o
);
  localparam logic [CTRL_W-1:0] CTRL_RST =
    CTRL_W'({PLEN_W{1'b1}}) << B_CLEN | CTRL_W'({PLEN_W{1'b1}}) << B_SLEN;

  logic              unlocked_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [PRE_W-1:0]  div_q;
  logic              tmo_sel;
  logic              cfg_hit;
  logic              cfg_wr;

  assign tmo_sel = (wr_addr_i >= A_TMO0) && (wr_addr_i < A_TMO0 + ADDR_W'(NSTG));
  assign cfg_hit = (wr_addr_i == A_CTRL) || (wr_addr_i == A_DIV) || tmo_sel;
  assign cfg_wr  = wr_en_i && unlocked_q && cfg_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
      ctrl_q     <= CTRL_RST;
      div_q      <= PRE_W'(PRE_RST);
    end else if (wr_en_i) begin
      if (wr_addr_i == A_LOCK) unlocked_q <= (wr_data_i == KEY);
      if (cfg_wr && wr_addr_i == A_CTRL) ctrl_q <= wr_data_i[CTRL_W-1:0];
      if (cfg_wr && wr_addr_i == A_DIV)  div_q  <= wr_data_i[PRE_W-1:0];
    end
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    logic [TMO_W-1:0] tmo_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tmo_q <= TMO_RST;
      else if (cfg_wr && wr_addr_i == A_TMO0 + ADDR_W'(s)) tmo_q <= wr_data_i[TMO_W-1:0];
    end
    assign tmo_o[s] = tmo_q;
    assign act_o[s] = ctrl_q[B_ACT0 + 2*s +: 2];
  end

  assign unlocked_o = unlocked_q;
  assign run_o      = ctrl_q[B_RUN] | ctrl_q[B_FBOOT];
  assign restart_o  = (wr_en_i && wr_addr_i == A_FEED) || cfg_wr;
  assign irq_clr_o  = wr_en_i && (wr_addr_i == A_ICLR) && wr_data_i[0];
  assign div_o      = div_q;
  assign cpu_len_o  = ctrl_q[B_CLEN +: PLEN_W];
  assign sys_len_o  = ctrl_q[B_SLEN +: PLEN_W];
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] last;

  assign last   = (div_i == '0) ? '0 : div_i - PRE_W'(1);
  assign tick_o = run_i && !restart_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || restart_i) cnt_q <= '0;
    else if (tick_o)             cnt_q <= '0;
    else                         cnt_q <= cnt_q + PRE_W'(1);
  end
endmodule

// File: rtl/wdg_sequencer.sv
module wdg_sequencer
  import wdg_pkg::*;
#(
  parameter int TMO_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       run_i,
  input  logic                       restart_i,
  input  logic                       tick_i,
  input  logic [NSTG-1:0][1:0]       act_i,
  input  logic [NSTG-1:0][TMO_W-1:0] tmo_i,
  output logic                       fire_irq_o,
  output logic                       fire_cpu_o,
  output logic                       fire_sys_o
);
  localparam int SW = $clog2(NSTG);

  logic [SW-1:0]    stage_q;
  logic [TMO_W-1:0] cnt_q;
  act_e             act;
  logic             active;
  logic             reached;
  logic             expire;

  assign act     = act_e'(act_i[stage_q]);
  assign active  = run_i && !restart_i;
  assign reached = ({1'b0, cnt_q} + (TMO_W+1)'(1)) >= {1'b0, tmo_i[stage_q]};
  assign expire  = active && (act != ACT_OFF) && tick_i && reached;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      cnt_q   <= '0;
    end else if (!active) begin
      stage_q <= '0;
      cnt_q   <= '0;
    end else if (act == ACT_OFF) begin
      stage_q <= stage_q + SW'(1);
      cnt_q   <= '0;
    end else if (tick_i) begin
      if (reached) begin
        stage_q <= stage_q + SW'(1);
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + TMO_W'(1);
      end
    end
  end

  assign fire_irq_o = expire && (act == ACT_IRQ);
  assign fire_cpu_o = expire && (act == ACT_CPU);
  assign fire_sys_o = expire && (act == ACT_SYS);
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
  parameter int PLEN_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [PLEN_W-1:0] len_i,
  output logic              pulse_o
);
  logic [PLEN_W:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              left_q <= '0;
    else if (fire_i)          left_q <= {1'b0, len_i} + (PLEN_W+1)'(1);
    else if (left_q != '0)    left_q <= left_q - (PLEN_W+1)'(1);
  end

  assign pulse_o = (left_q != '0);
endmodule

// File: rtl/wdg_escalator.sv
module wdg_escalator
  import wdg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TMO_W  = 32,
  parameter int PRE_W  = 16,
  parameter int PLEN_W = 3,
  parameter logic [DATA_W-1:0] KEY = 32'h50D8_3AA1,
  parameter int PRE_RST = 80
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              irq_o,
  output logic              cpu_rst_o,
  output logic              sys_rst_o
);
  logic                       unlocked_w;
  logic                       run_w;
  logic                       restart_w;
  logic                       irq_clr_w;
  logic [NSTG-1:0][1:0]       act_w;
  logic [NSTG-1:0][TMO_W-1:0] tmo_w;
  logic [PRE_W-1:0]           div_w;
  logic [PLEN_W-1:0]          cpu_len_w;
  logic [PLEN_W-1:0]          sys_len_w;
  logic                       tick_w;
  logic                       fire_irq_w;
  logic                       fire_cpu_w;
  logic                       fire_sys_w;
  logic                       irq_q;

  wdg_regs #(
    .DATA_W(DATA_W), .TMO_W(TMO_W), .PRE_W(PRE_W), .PLEN_W(PLEN_W),
    .KEY(KEY), .PRE_RST(PRE_RST)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .unlocked_o(unlocked_w), .run_o(run_w), .restart_o(restart_w),
    .irq_clr_o(irq_clr_w), .act_o(act_w), .tmo_o(tmo_w), .div_o(div_w),
    .cpu_len_o(cpu_len_w), .sys_len_o(sys_len_w)
  );

  wdg_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_w), .restart_i(restart_w),
    .div_i(div_w), .tick_o(tick_w)
  );

  wdg_sequencer #(.TMO_W(TMO_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_w), .restart_i(restart_w),
    .tick_i(tick_w), .act_i(act_w), .tmo_i(tmo_w),
    .fire_irq_o(fire_irq_w), .fire_cpu_o(fire_cpu_w), .fire_sys_o(fire_sys_w)
  );

  logic [1:0]             rst_fire;
  logic [1:0][PLEN_W-1:0] rst_len;
  logic [1:0]             rst_pulse;

  assign rst_fire = {fire_sys_w, fire_cpu_w};
  assign rst_len  = {sys_len_w, cpu_len_w};

  for (genvar k = 0; k < 2; k++) begin : g_pulse
    wdg_pulse #(.PLEN_W(PLEN_W)) u_pulse (
      .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(rst_fire[k]),
      .len_i(rst_len[k]), .pulse_o(rst_pulse[k])
    );
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         irq_q <= 1'b0;
    else if (fire_irq_w) irq_q <= 1'b1;
    else if (irq_clr_w)  irq_q <= 1'b0;
  end

  assign irq_o     = irq_q;
  assign cpu_rst_o = rst_pulse[0];
  assign sys_rst_o = rst_pulse[1];
endmodule

// File: rtl/wdg_escalator_chk.sv
module wdg_escalator_chk
  import wdg_pkg::*;
#(
  parameter int TMO_W = 32,
  parameter int PRE_W = 16
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_en_i,
  input logic [ADDR_W-1:0]          wr_addr_i,
  input logic                       irq_o,
  input logic                       cpu_rst_o,
  input logic                       sys_rst_o,
  input logic                       unlocked_w,
  input logic                       run_w,
  input logic                       irq_clr_w,
  input logic                       fire_irq_w,
  input logic                       fire_cpu_w,
  input logic                       fire_sys_w,
  input logic [NSTG-1:0][1:0]       act_w,
  input logic [NSTG-1:0][TMO_W-1:0] tmo_w,
  input logic [PRE_W-1:0]           div_w
);
  assert_locked_cfg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !unlocked_w && wr_addr_i != A_FEED) |=>
      ($stable(act_w) && $stable(tmo_w) && $stable(div_w)));

  assert_single_action_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fire_irq_w, fire_cpu_w, fire_sys_w}));

  assert_feed_suppresses_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_FEED) |=>
      (!$rose(irq_o) && !$rose(cpu_rst_o) && !$rose(sys_rst_o)));

  assert_stopped_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_w |=> (!$rose(irq_o) && !$rose(cpu_rst_o) && !$rose(sys_rst_o)));

  assert_irq_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_w) |=> irq_o);

  assert_irq_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_w && !fire_irq_w) |=> !irq_o);
endmodule

bind wdg_escalator wdg_escalator_chk #(.TMO_W(TMO_W), .PRE_W(PRE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .irq_o(irq_o), .cpu_rst_o(cpu_rst_o), .sys_rst_o(sys_rst_o),
  .unlocked_w(unlocked_w), .run_w(run_w), .irq_clr_w(irq_clr_w),
  .fire_irq_w(fire_irq_w), .fire_cpu_w(fire_cpu_w), .fire_sys_w(fire_sys_w),
  .act_w(act_w), .tmo_w(tmo_w), .div_w(div_w)
);

// File: tb/wdg_escalator_test.sv
`timescale 1ns/1ps
module wdg_escalator_test;
  localparam logic [31:0] KEY = 32'h50D8_3AA1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        irq, cpu_rst, sys_rst;

  always #4 clk = ~clk;

  wdg_escalator uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .irq_o(irq), .cpu_rst_o(cpu_rst), .sys_rst_o(sys_rst)
  );

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  // ---------------- behavioural reference model ----------------
  int          m_unl, m_ctrl, m_div, m_stage, m_pcnt, m_irq, m_cpu, m_sys;
  longint      m_tcnt;
  longint      m_tmo[4];
  int          coll_irq = 0, coll_feed = 0;

  function automatic int act_of(int ctrl, int s);
    return (ctrl >> (2 + 2*s)) & 3;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_unl = 0; m_ctrl = 16'hFC00; m_div = 80; m_stage = 0; m_pcnt = 0;
      m_tcnt = 0; m_irq = 0; m_cpu = 0; m_sys = 0;
      for (int s = 0; s < 4; s++) m_tmo[s] = 64'hFFFF_FFFF;
    end else begin
      int run, is_cfg, restart, feed, clr, deff, tick, a, expire, would;
      longint tm;
      run     = ((m_ctrl & 3) != 0);
      is_cfg  = (wr_addr == 1 || wr_addr == 2 || (wr_addr >= 4 && wr_addr <= 7));
      feed    = wr_en && wr_addr == 3;
      restart = feed || (wr_en && m_unl && is_cfg);
      clr     = wr_en && wr_addr == 8 && wr_data[0];
      deff    = (m_div == 0) ? 1 : m_div;
      tick    = run && !restart && (m_pcnt >= deff - 1);
      a       = act_of(m_ctrl, m_stage);
      tm      = (m_tmo[m_stage] == 0) ? 1 : m_tmo[m_stage];
      would   = run && a != 0 && (m_pcnt >= deff - 1) && (m_tcnt + 1 >= tm);
      expire  = 0;
      if (!run || !(!restart)) begin
        if (feed && would) coll_feed++;
        m_stage = 0; m_tcnt = 0;
      end else if (a == 0) begin
        m_stage = (m_stage + 1) % 4; m_tcnt = 0;
      end else if (tick) begin
        if (m_tcnt + 1 >= tm) begin
          expire = 1; m_stage = (m_stage + 1) % 4; m_tcnt = 0;
        end else m_tcnt++;
      end
      if (!run || restart || tick) m_pcnt = 0; else m_pcnt++;
      if (expire && a == 2) m_cpu = ((m_ctrl >> 10) & 7) + 1;
      else if (m_cpu > 0) m_cpu--;
      if (expire && a == 3) m_sys = ((m_ctrl >> 13) & 7) + 1;
      else if (m_sys > 0) m_sys--;
      if (expire && a == 1) begin
        if (clr) coll_irq++;
        m_irq = 1;
      end else if (clr) m_irq = 0;
      if (wr_en && m_unl) begin
        if (wr_addr == 1) m_ctrl = int'(wr_data[15:0]);
        if (wr_addr == 2) m_div  = int'(wr_data[15:0]);
        if (wr_addr >= 4 && wr_addr <= 7) m_tmo[wr_addr-4] = longint'(wr_data);
      end
      if (wr_en && wr_addr == 0) m_unl = (wr_data == KEY);
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison plus pulse-length and rise monitors
  int cpu_run = 0, sys_run = 0, cpu_last = 0, sys_last = 0;
  int irq_rises = 0, cpu_rises = 0, sys_rises = 0;
  logic p_irq = 0, p_cpu = 0, p_sys = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check(cur_req, "irq_o", int'(irq), m_irq);
      check(cur_req, "cpu_rst_o", int'(cpu_rst), int'(m_cpu != 0));
      check(cur_req, "sys_rst_o", int'(sys_rst), int'(m_sys != 0));
    end
    if (cpu_rst) cpu_run++; else if (cpu_run > 0) begin cpu_last = cpu_run; cpu_run = 0; end
    if (sys_rst) sys_run++; else if (sys_run > 0) begin sys_last = sys_run; sys_run = 0; end
    if (irq && !p_irq) irq_rises++;
    if (cpu_rst && !p_cpu) cpu_rises++;
    if (sys_rst && !p_sys) sys_rises++;
    p_irq = irq; p_cpu = cpu_rst; p_sys = sys_rst;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input int addr, input logic [31:0] data);
    wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] mk_ctrl(int en, int fb, int a0, int a1, int a2, int a3, int cl, int sl);
    return 32'(en | fb << 1 | a0 << 2 | a1 << 4 | a2 << 6 | a3 << 8 | cl << 10 | sl << 13);
  endfunction

  initial begin
    int r0, r1;
    @(negedge clk); @(negedge clk);
    // R1: outputs quiet in reset
    check("R1", "irq in reset", int'(irq), 0);
    check("R1", "cpu in reset", int'(cpu_rst), 0);
    check("R1", "sys in reset", int'(sys_rst), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: locked writes ignored
    cur_req = "R2";
    wr(2, 2); wr(4, 1); wr(1, mk_ctrl(1, 0, 1, 2, 3, 1, 0, 0));
    idle(300);
    check("R2", "no irq while locked", irq_rises, 0);
    check("R2", "no sys while locked", sys_rises, 0);
    // a wrong key leaves it locked
    wr(0, 32'h50D8_3AA0); wr(1, mk_ctrl(1, 0, 3, 3, 3, 3, 0, 0));
    idle(300);
    check("R2", "wrong key stays locked", sys_rises, 0);

    // R4 R5 R8: full escalation
    cur_req = "R4";
    wr(0, KEY);
    wr(2, 2); wr(4, 3); wr(5, 2); wr(6, 2); wr(7, 2);
    wr(1, mk_ctrl(1, 0, 1, 0, 2, 3, 2, 7));
    idle(80);
    check("R4", "irq raised by stage 0", int'(irq), 1);
    check("R8", "cpu pulse length L=2", cpu_last, 3);
    check("R8", "sys pulse length L=7", sys_last, 8);
    check("R5", "cpu stage fired", int'(cpu_rises > 0), 1);

    // R7: clear
    cur_req = "R7";
    wr(1, mk_ctrl(0, 0, 1, 0, 2, 3, 2, 7));
    wr(8, 1);
    @(negedge clk);
    check("R7", "irq cleared", int'(irq), 0);
    wr(8, 0);
    // R7 collision sweep: clear at varying delay after a feed
    wr(1, mk_ctrl(1, 0, 1, 1, 1, 1, 0, 0));
    for (int d = 0; d < 14; d++) begin
      wr(3, 0); idle(d); wr(8, 1); idle(2);
    end
    check("R7", "set/clear coincidence seen", int'(coll_irq > 0), 1);

    // R6: feed sweep and steady feeding
    cur_req = "R6";
    wr(1, mk_ctrl(1, 0, 3, 3, 3, 3, 0, 0));
    for (int d = 0; d < 14; d++) begin
      wr(3, 0); idle(d); wr(3, 0); idle(12);
    end
    check("R6", "feed/expiry coincidence seen", int'(coll_feed > 0), 1);
    r0 = sys_rises;
    for (int i = 0; i < 40; i++) begin wr(3, 0); idle(2); end
    check("R6", "steady feeding prevents firing", sys_rises - r0, 0);

    // R2: relock, then a stop request is ignored
    cur_req = "R2";
    wr(0, 0);
    wr(1, 0);
    r1 = sys_rises;
    idle(60);
    check("R2", "relocked: disable ignored", int'(sys_rises > r1), 1);

    // R3: divide of zero behaves as one
    cur_req = "R3";
    wr(0, KEY); wr(2, 0); wr(4, 5);
    wr(1, mk_ctrl(1, 0, 3, 0, 0, 0, 0, 0));
    idle(40);
    check("R3", "divide 0 produced firing", int'(sys_rises > r1), 1);

    // R9: flash-boot alone runs the watchdog; all stopped is quiet
    cur_req = "R9";
    wr(1, mk_ctrl(0, 0, 3, 3, 3, 3, 0, 0));
    r1 = sys_rises;
    idle(40);
    check("R9", "stopped watchdog silent", sys_rises - r1, 0);
    wr(1, mk_ctrl(0, 1, 3, 3, 3, 3, 0, 0));
    idle(40);
    check("R9", "flash-boot enable runs", int'(sys_rises > r1), 1);

    // R5: all stages off never fire
    cur_req = "R5";
    wr(1, mk_ctrl(1, 0, 0, 0, 0, 0, 0, 0));
    r0 = sys_rises + cpu_rises + irq_rises;
    idle(60);
    check("R5", "all-off fires nothing", sys_rises + cpu_rises + irq_rises - r0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule